// File: doc/BRIEF.md
# Binary-Mode 8-Bit Accumulator ALU

This block is the arithmetic and logic stage of a small accumulator CPU. It does binary arithmetic only, with no decimal mode. On each clock it samples the following inputs: an operation code, the accumulator, the X index register, an operand byte and the incoming status flags. One cycle later it presents the result byte, a code naming where that byte should be written, and the updated flags.

The surrounding core keeps the registers and does all instruction decode. It feeds the registered outputs back into its register file or memory write path according to the destination code. The block covers the following:

- add and subtract with carry
- compares against A or X
- AND, OR and XOR
- bit test
- increment and decrement of memory or X
- shifts and rotates on memory or on A
- a pass-through load
- a combined operation that subtracts the operand from A AND X and writes the difference to X

Top module: `alu8_core`

## Requirements
- R1: While reset is high at a clock edge, the next outputs are result 0, destination 0 and flags 0. Flags are packed as bit 3 N, bit 2 V, bit 1 Z, bit 0 C. Destination codes are 0 none, 1 accumulator, 2 X register, 3 memory.
- R2: Outputs are registered. Inputs applied before a rising edge appear only after that edge, and not before it.
- R3: ADC (code 0) gives A+M+C modulo 256, with destination 1. C is bit 8 of the 9-bit sum. V is set when A and M agree in bit 7 and the result differs from A in bit 7.
- R4: SBC (code 1) gives A−M−(1−C) modulo 256, with destination 1. C is set when no borrow occurs. V is bit 7 of (A XOR R) AND (A XOR M).
- R5: Compare with A (code 2) or X (code 3) outputs reg−M with destination 0. C is set when reg ≥ M unsigned, and V passes through.
- R6: AND (4), OR (5) and XOR (6) combine A with M, with destination 1. C and V pass through.
- R7: Bit test (code 7) outputs A AND M with destination 0. Z is set when that value is zero. N is set to M bit 7 and V to M bit 6. C passes through.
- R8: Increment and decrement of M (codes 8 and 9, destination 3) and of X (codes 10 and 11, destination 2) wrap modulo 256. C and V pass through.
- R9: Shift-left and rotate-left act on M (codes 12 and 14, destination 3) or on A (codes 16 and 18, destination 1). C receives the old bit 7. Rotate shifts the old C into bit 0, while shift fills bit 0 with 0. V passes through.
- R10: Shift-right and rotate-right act on M (codes 13 and 15, destination 3) or on A (codes 17 and 19, destination 1). C receives the old bit 0. Rotate shifts the old C into bit 7, and shift-right leaves N clear. V passes through.
- R11: Code 20 outputs (A AND X)−M modulo 256 with destination 2. C is set when no borrow occurs, and V passes through.
- R12: Load (code 21) outputs M with destination 1. For every defined code except bit test, Z is set when the result is zero and N copies result bit 7.
- R13: Codes 22 to 31 output result 0 and destination 0, and pass all four flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| xreg_i | input | 8 | X register value |
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 4 | Incoming flags {N,V,Z,C} |
| result_o | output | 8 | Registered result byte |
| dest_o | output | 2 | Registered destination code |
| flags_o | output | 4 | Registered updated flags {N,V,Z,C} |

## Verification
The bench targets the following corner cases, and the effect of getting each one wrong:

- **Signed overflow at 0x7F/0x80.** An overflow rule taken from the carry would flag 0xFF+0x01 and miss 0x50+0x50.
- **Borrow sense of subtract and compare.** An inverted borrow would report A < M on equal compares and break multi-byte subtraction chains.
- **Carry into bit 0 or bit 7 on rotates.** A missing carry-in would drop the old C.
- **Flags that must pass through.** A logical operation, increment or undefined code that clobbers C or V would corrupt a pending carry.
- **Bit test and the combined operation.** Bit test takes N and V from the operand rather than the result, and the combined operation must write X, not A.

ADC and SBC are swept over every operand pair.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADC  = 5'd0,
    OP_SBC  = 5'd1,
    OP_CMPA = 5'd2,
    OP_CMPX = 5'd3,
    OP_AND  = 5'd4,
    OP_ORA  = 5'd5,
    OP_EOR  = 5'd6,
    OP_BIT  = 5'd7,
    OP_INCM = 5'd8,
    OP_DECM = 5'd9,
    OP_INX  = 5'd10,
    OP_DEX  = 5'd11,
    OP_ASLM = 5'd12,
    OP_LSRM = 5'd13,
    OP_ROLM = 5'd14,
    OP_RORM = 5'd15,
    OP_ASLA = 5'd16,
    OP_LSRA = 5'd17,
    OP_ROLA = 5'd18,
    OP_RORA = 5'd19,
    OP_AXS  = 5'd20,
    OP_LDA  = 5'd21
  } alu_op_e;

  localparam logic [4:0] OP_LAST_DEFINED = 5'd21;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_XREG = 2'd2,
    DST_MEM  = 2'd3
  } alu_dst_e;

  typedef enum logic [2:0] {
    UN_PASS = 3'd0,
    UN_ASL  = 3'd1,
    UN_LSR  = 3'd2,
    UN_ROL  = 3'd3,
    UN_ROR  = 3'd4,
    UN_INC  = 3'd5,
    UN_DEC  = 3'd6
  } unary_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_e;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 2;
  localparam int FLG_N = 3;
  localparam int FLG_W = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] rhs_eff;
  logic [W:0]   wide;

  // Subtraction is lhs + ~rhs + cin, so cout reads directly as "no borrow".
  assign rhs_eff = sub ? ~rhs : rhs;
  assign wide    = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
  assign sum     = wide[W-1:0];
  assign cout    = wide[W];
  assign ovf     = ~(lhs[W-1] ^ rhs_eff[W-1]) & (lhs[W-1] ^ wide[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_e       sel,
  output logic [W-1:0] y
);
  always_comb begin
    case (sel)
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  unary_e       kind,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    y    = val;
    cout = cin;
    case (kind)
      UN_ASL: begin y = {val[W-2:0], 1'b0}; cout = val[W-1]; end
      UN_ROL: begin y = {val[W-2:0], cin};  cout = val[W-1]; end
      UN_LSR: begin y = {1'b0, val[W-1:1]}; cout = val[0];   end
      UN_ROR: begin y = {cin, val[W-1:1]};  cout = val[0];   end
      UN_INC: y = val + ONE;
      UN_DEC: y = val - ONE;
      default: y = val;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] xreg_i,
  input  logic [W-1:0] opnd_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic [1:0]   dest_o,
  output logic [3:0]   flags_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Operand steering for the shared adder and the unary unit.
  logic [W-1:0] as_lhs, as_sum, un_val, un_res, lg_res;
  logic         as_sub, as_cin, as_cout, as_ovf, un_cout;
  unary_e       un_kind;
  logic_e       lg_sel;

  always_comb begin
    as_lhs  = acc_i;
    as_sub  = 1'b0;
    as_cin  = flags_i[FLG_C];
    un_kind = UN_PASS;
    un_val  = opnd_i;
    lg_sel  = LG_AND;
    case (op)
      OP_SBC:  as_sub = 1'b1;
      OP_CMPA: begin as_sub = 1'b1; as_cin = 1'b1; end
      OP_CMPX: begin as_sub = 1'b1; as_cin = 1'b1; as_lhs = xreg_i; end
      OP_AXS:  begin as_sub = 1'b1; as_cin = 1'b1; as_lhs = acc_i & xreg_i; end
      OP_ORA:  lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_XOR;
      OP_INCM: un_kind = UN_INC;
      OP_DECM: un_kind = UN_DEC;
      OP_INX:  begin un_kind = UN_INC; un_val = xreg_i; end
      OP_DEX:  begin un_kind = UN_DEC; un_val = xreg_i; end
      OP_ASLM: un_kind = UN_ASL;
      OP_LSRM: un_kind = UN_LSR;
      OP_ROLM: un_kind = UN_ROL;
      OP_RORM: un_kind = UN_ROR;
      OP_ASLA: begin un_kind = UN_ASL; un_val = acc_i; end
      OP_LSRA: begin un_kind = UN_LSR; un_val = acc_i; end
      OP_ROLA: begin un_kind = UN_ROL; un_val = acc_i; end
      OP_RORA: begin un_kind = UN_ROR; un_val = acc_i; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .lhs(as_lhs), .rhs(opnd_i), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(acc_i), .b(opnd_i), .sel(lg_sel), .y(lg_res)
  );

  alu8_unary #(.W(W)) u_unary (
    .val(un_val), .kind(un_kind), .cin(flags_i[FLG_C]),
    .y(un_res), .cout(un_cout)
  );

  // Result and flag merge; undefined flags default to the incoming ones.
  logic [W-1:0] res_n;
  alu_dst_e     dst_n;
  logic [3:0]   flg_n;
  logic         upd_z, upd_n;

  always_comb begin
    res_n = '0;
    dst_n = DST_NONE;
    flg_n = flags_i;
    upd_z = 1'b1;
    upd_n = 1'b1;
    case (op)
      OP_ADC, OP_SBC: begin
        res_n = as_sum; dst_n = DST_ACC;
        flg_n[FLG_C] = as_cout; flg_n[FLG_V] = as_ovf;
      end
      OP_CMPA, OP_CMPX: begin
        res_n = as_sum; flg_n[FLG_C] = as_cout;
      end
      OP_AXS: begin
        res_n = as_sum; dst_n = DST_XREG; flg_n[FLG_C] = as_cout;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res_n = lg_res; dst_n = DST_ACC;
      end
      OP_BIT: begin
        res_n = lg_res; upd_n = 1'b0;
        flg_n[FLG_N] = opnd_i[W-1];
        flg_n[FLG_V] = opnd_i[W-2];
      end
      OP_INCM, OP_DECM: begin
        res_n = un_res; dst_n = DST_MEM;
      end
      OP_INX, OP_DEX: begin
        res_n = un_res; dst_n = DST_XREG;
      end
      OP_ASLM, OP_LSRM, OP_ROLM, OP_RORM: begin
        res_n = un_res; dst_n = DST_MEM; flg_n[FLG_C] = un_cout;
      end
      OP_ASLA, OP_LSRA, OP_ROLA, OP_RORA: begin
        res_n = un_res; dst_n = DST_ACC; flg_n[FLG_C] = un_cout;
      end
      OP_LDA: begin
        res_n = opnd_i; dst_n = DST_ACC;
      end
      default: begin
        upd_z = 1'b0; upd_n = 1'b0;
      end
    endcase
    if (upd_z) flg_n[FLG_Z] = (res_n == '0);
    if (upd_n) flg_n[FLG_N] = res_n[W-1];
  end

  // Output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      dest_o   <= DST_NONE;
      flags_o  <= '0;
    end else begin
      result_o <= res_n;
      dest_o   <= dst_n;
      flags_o  <= flg_n;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result_o == '0 && dest_o == 2'd0 && flags_o == 4'd0)); // R1

  AST_ADC_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADC) |=> (flags_o[FLG_V] ==
      (($past(acc_i[W-1]) == $past(opnd_i[W-1])) && (result_o[W-1] != $past(acc_i[W-1]))))); // R3

  AST_CMP_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMPA) |=> (dest_o == 2'd0 && flags_o[FLG_C] == ($past(acc_i) >= $past(opnd_i)))); // R5

  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND || op == OP_ORA || op == OP_EOR) |=>
      (flags_o[FLG_C] == $past(flags_i[FLG_C]) && flags_o[FLG_V] == $past(flags_i[FLG_V]))); // R6

  AST_BIT_FROM_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BIT) |=> (flags_o[FLG_N] == $past(opnd_i[W-1]) &&
      flags_o[FLG_V] == $past(opnd_i[W-2]) && dest_o == 2'd0)); // R7

  AST_SHR_N_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LSRM || op == OP_LSRA) |=> !flags_o[FLG_N]); // R10

  AST_AXS_TO_X: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AXS) |=> (dest_o == 2'd2)); // R11

  AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op_i <= OP_LAST_DEFINED) |=> (flags_o[FLG_Z] == (result_o == '0))); // R12

  AST_UNDEF_PASSES: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_LAST_DEFINED) |=> (flags_o == $past(flags_i) && dest_o == 2'd0)); // R13

endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, xreg_i = '0, opnd_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] result_o;
  logic [1:0] dest_o;
  logic [3:0] flags_o;

  int checks = 0;
  int fails  = 0;
  logic [13:0] pend_exp;
  bit          pend_valid = 0;
  int          pend_op;

  always #2.5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .xreg_i(xreg_i),
    .opnd_i(opnd_i), .flags_i(flags_i), .result_o(result_o),
    .dest_o(dest_o), .flags_o(flags_o)
  );

  // Behavioural reference: returns {result[7:0], dest[1:0], N, V, Z, C}.
  function automatic logic [13:0] ref_model(int op, int a, int x, int m, logic [3:0] f);
    int r, c, c0, v, z, n, d, t;
    bit zn;
    c0 = f[0]; c = f[0]; z = f[1]; v = f[2]; n = f[3]; d = 0; zn = 1; r = 0;
    case (op)
      0: begin t = a + m + c0; c = (t >> 8) & 1; r = t & 255;
               v = (((a ^ m) & 128) == 0 && ((a ^ r) & 128) != 0); d = 1; end
      1: begin t = a - m - (1 - c0); c = (t >= 0); r = t & 255;
               v = (((a ^ r) & (a ^ m) & 128) != 0); d = 1; end
      2: begin c = (a >= m); r = (a - m) & 255; end
      3: begin c = (x >= m); r = (x - m) & 255; end
      4: begin r = a & m; d = 1; end
      5: begin r = a | m; d = 1; end
      6: begin r = a ^ m; d = 1; end
      7: begin r = a & m; v = (m >> 6) & 1; n = (m >> 7) & 1; end
      8: begin r = (m + 1) & 255; d = 3; end
      9: begin r = (m - 1) & 255; d = 3; end
      10: begin r = (x + 1) & 255; d = 2; end
      11: begin r = (x - 1) & 255; d = 2; end
      12, 16: begin t = (op == 12) ? m : a; c = (t >> 7) & 1; r = (t << 1) & 255; d = (op == 12) ? 3 : 1; end
      13, 17: begin t = (op == 13) ? m : a; c = t & 1; r = t >> 1; d = (op == 13) ? 3 : 1; end
      14, 18: begin t = (op == 14) ? m : a; c = (t >> 7) & 1; r = ((t << 1) | c0) & 255; d = (op == 14) ? 3 : 1; end
      15, 19: begin t = (op == 15) ? m : a; c = t & 1; r = (t >> 1) | (c0 << 7); d = (op == 15) ? 3 : 1; end
      20: begin t = (a & x) - m; c = (t >= 0); r = t & 255; d = 2; end
      21: begin r = m; d = 1; end
      default: begin r = 0; d = 0; zn = 0; end
    endcase
    if (zn) begin
      z = (r == 0);
      if (op != 7) n = (r >> 7) & 1;
    end
    return {r[7:0], d[1:0], n[0], v[0], z[0], c[0]};
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5, 6: return "R6";
      7: return "R7";
      8, 9, 10, 11: return "R8";
      12, 14, 16, 18: return "R9";
      13, 15, 17, 19: return "R10";
      20: return "R11";
      21: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_pending();
    logic [13:0] got;
    got = {result_o, dest_o, flags_o};
    if (pend_valid) begin
      checks++;
      if (got !== pend_exp) begin
        fails++;
        $display("FAIL %s op=%0d actual res=%h dest=%0d flags=%b expected res=%h dest=%0d flags=%b",
                 req_of(pend_op), pend_op, got[13:6], got[5:4], got[3:0],
                 pend_exp[13:6], pend_exp[5:4], pend_exp[3:0]);
      end
    end
  endtask

  // At a falling edge: check the previous operation's outputs, then drive the next.
  task automatic apply(int op, int a, int x, int m, logic [3:0] f);
    @(negedge clk);
    check_pending();
    op_i = op[4:0]; acc_i = a[7:0]; xreg_i = x[7:0]; opnd_i = m[7:0]; flags_i = f;
    pend_exp = ref_model(op, a, x, m, f);
    pend_op = op;
    pend_valid = 1;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    op_i = 5'd0; acc_i = 8'h55; opnd_i = 8'h66; flags_i = 4'hF;
    repeat (3) @(negedge clk);
    checks++;
    if ({result_o, dest_o, flags_o} !== 14'd0) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=0", {result_o, dest_o, flags_o});
    end
    @(negedge clk);
    rst = 1'b0;
    op_i = 5'd0; acc_i = 8'h01; xreg_i = 8'h00; opnd_i = 8'h01; flags_i = 4'h0;
    #1;
    checks++;
    if (result_o !== 8'h00) begin
      fails++;
      $display("FAIL R2 output before edge actual=%h expected=00", result_o);
    end
    pend_exp = ref_model(0, 1, 0, 1, 4'h0); pend_op = 0; pend_valid = 1;

    // R3 overflow and carry corners
    apply(0, 8'h50, 0, 8'h50, 4'h0);
    apply(0, 8'hFF, 0, 8'h01, 4'h0);
    apply(0, 8'h7F, 0, 8'h00, 4'h1);
    apply(0, 8'h80, 0, 8'h80, 4'h0);
    // R4 borrow and overflow corners
    apply(1, 8'h00, 0, 8'h01, 4'h1);
    apply(1, 8'h80, 0, 8'h01, 4'h1);
    apply(1, 8'h50, 0, 8'hB0, 4'h0);
    // R5 equal and less-than compares
    apply(2, 8'h42, 0, 8'h42, 4'h4);
    apply(2, 8'h10, 0, 8'h20, 4'h5);
    apply(3, 0, 8'hFF, 8'h00, 4'h0);
    // R6 pass-through of C and V
    apply(4, 8'hF0, 0, 8'h0F, 4'h5);
    apply(5, 8'h80, 0, 8'h01, 4'h5);
    apply(6, 8'hAA, 0, 8'hAA, 4'h0);
    // R7 bit test
    apply(7, 8'h3F, 0, 8'hC0, 4'h1);
    apply(7, 8'hFF, 0, 8'h01, 4'hE);
    // R8 wrap
    apply(8, 0, 0, 8'hFF, 4'h5);
    apply(9, 0, 0, 8'h00, 4'h0);
    apply(10, 0, 8'h7F, 0, 4'h0);
    apply(11, 0, 8'h00, 0, 4'h5);
    // R9 and R10 shifts and rotates with carry in
    apply(12, 0, 0, 8'h80, 4'h0);
    apply(14, 0, 0, 8'h80, 4'h1);
    apply(18, 8'h00, 0, 0, 4'h1);
    apply(13, 0, 0, 8'h01, 4'h8);
    apply(15, 0, 0, 8'h01, 4'h1);
    apply(19, 8'h00, 0, 0, 4'h1);
    apply(17, 8'hFF, 0, 0, 4'h0);
    apply(16, 8'h40, 0, 0, 4'h4);
    // R11 combined operation, zero and borrow
    apply(20, 8'hF0, 8'h3C, 8'h30, 4'h0);
    apply(20, 8'hF0, 8'h3C, 8'h31, 4'h5);
    // R12 load
    apply(21, 0, 0, 8'h00, 4'h8);
    apply(21, 0, 0, 8'h9C, 4'h2);
    // R13 undefined codes
    apply(22, 8'h12, 8'h34, 8'h56, 4'hA);
    apply(31, 8'hFF, 8'hFF, 8'hFF, 4'h5);

    // R3 and R4 swept over all operand pairs
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        apply(0, a, 0, m, {3'b000, 1'((a ^ m) & 1)});
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        apply(1, a, 0, m, {3'b000, 1'(a & 1)});

    // Random mix over all codes
    for (int i = 0; i < 4000; i++)
      apply(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            4'($urandom_range(0, 15)));

    @(negedge clk);
    check_pending();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule